// File: doc/BRIEF.md
# Differential Counter-Pair Synapse Array

This block holds the pairwise weights of a small binary restricted Boltzmann machine with 9 visible and 5 hidden units, 45 synapses in all. Each synapse is stored as two saturating counters that can only count upward: a positive cell and a negative cell. The effective weight is the positive cell minus the negative cell. A training controller moves a weight by naming the synapse and the sign of the wanted change. The sign selects which of the two cells takes one step. The array never holds a single signed register per weight.

An initialise command loads every cell with a small value near zero, the low-conductance end. Each value comes from a seeded pseudo-random sequence, so the weights do not start out identical. While the cells are loaded, the array sums the 45 differences. It then divides the sum by the synapse count to obtain an offset M, and holds M until the next initialise. The read port returns a normalised weight for any visible/hidden pair: the difference minus M, divided by a power-of-two spread through an arithmetic right shift. The bias terms of the model are fixed at zero and are not stored.

Top module: `srm_synapse_array`

## Requirements
- R1: After reset, busy_o is 0, upd_ready_o is 1 and rd_valid_o is 0.
- R2: A one-cycle init_i while idle raises busy_o from the following cycle. busy_o then stays high, and upd_ready_o low, until the offset M has been captured. An init_i that arrives while busy is ignored.
- R3: Initialisation visits the synapses in ascending order of index s = v*5 + h. For each synapse, the 16-bit shift register (reloaded with SEED on every initialise) is advanced twice with next = {x[14:0], x[15]^x[13]^x[12]^x[10]}. After the first step, the positive cell takes the low INIT_BITS bits, zero-extended. After the second step, the negative cell takes them.
- R4: M is the sum of the 45 initial differences (positive minus negative), divided by 45 and truncated toward zero. M is captured at the end of initialisation and stays unchanged until the next initialise.
- R5: A request on rd_req_i with rd_vis_i = v and rd_hid_i = h makes rd_valid_o 1 in the next cycle. In that cycle, rd_weight_o holds floor((pos - neg - M) / 2^NORM_SHIFT) as a 12-bit two's complement value.
- R6: An update is accepted in a cycle where upd_valid_i and upd_ready_o are both 1. With upd_pos_i = 1 it adds 1 to the positive cell of synapse upd_idx_i. With upd_pos_i = 0 it adds 1 to the negative cell. The partner cell is left as it was.
- R7: A cell at 255 stays at 255 when it is stepped again. It never wraps.
- R8: An accepted update with upd_idx_i of 45 to 63 changes no cell.
- R9: Updates may be accepted on consecutive cycles, and each one adds exactly one step.
- R10: A repeated initialise restores the same cell values and the same M as the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Initialise command pulse |
| busy_o | output | 1 | High while initialisation runs |
| upd_valid_i | input | 1 | Update request valid |
| upd_ready_o | output | 1 | Update request can be accepted |
| upd_idx_i | input | 6 | Synapse index v*5+h |
| upd_pos_i | input | 1 | 1 steps the positive cell, 0 steps the negative cell |
| rd_req_i | input | 1 | Read request |
| rd_vis_i | input | 4 | Visible unit index 0..8 |
| rd_hid_i | input | 3 | Hidden unit index 0..4 |
| rd_valid_o | output | 1 | Read result valid |
| rd_weight_o | output | 12 | Normalised signed weight |

## Verification
A wrong cell value shows up at the read port on the next read of that synapse. The bench therefore reads all 45 synapses after each phase, so a corrupted, wrapped or misrouted cell is reported within one sweep. A wrong M, or a wrong initial sequence, moves many weights at once, and the first sweep after initialisation catches it. Updates to indices 45 to 63 and saturated cells are followed by full sweeps, so a step that reached the wrong cell is seen before the next stimulus.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DIV  = 2'd2
  } srm_state_e;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/srm_cell_bank.sv
module srm_cell_bank #(
  parameter int CW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_we,
  input  logic [AW-1:0] init_addr,
  input  logic [CW-1:0] init_val,
  input  logic          inc_en,
  input  logic [AW-1:0] inc_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_val
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] inc_old;
  logic [CW-1:0] inc_new;
  logic [AW-1:0] waddr;
  logic [CW-1:0] wdata;
  logic          we;

  assign inc_old = mem[inc_addr];
  assign inc_new = (inc_old == CMAX) ? CMAX : inc_old + 1'b1;
  assign we      = init_we | inc_en;
  assign waddr   = init_we ? init_addr : inc_addr;
  assign wdata   = init_we ? init_val  : inc_new;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_val = mem[rd_addr];

  // checker state: remember the last increment
  logic          chk_v;
  logic [AW-1:0] chk_addr;
  logic [CW-1:0] chk_old;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v    <= 1'b0;
      chk_addr <= '0;
      chk_old  <= '0;
    end else begin
      chk_v    <= inc_en & ~init_we;
      chk_addr <= inc_addr;
      chk_old  <= inc_old;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (chk_v && chk_old == CMAX) |-> mem[chk_addr] == CMAX);

  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    (chk_v && chk_old != CMAX) |-> mem[chk_addr] == chk_old + 1'b1);
endmodule

// File: rtl/srm_mean_div.sv
module srm_mean_div #(
  parameter int DW      = 15,
  parameter int DIVISOR = 45,
  localparam int RW     = $clog2(DIVISOR) + 1,
  localparam int CNTW   = $clog2(DW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic signed [DW-1:0] dividend_i,
  output logic                 done_o,
  output logic signed [DW-1:0] quot_o
);
  logic [DW-1:0]   mag_q;
  logic [DW-1:0]   qd_q;
  logic [RW-1:0]   rem_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q;
  logic            neg_q;
  logic [RW:0]     trial;
  logic            ge;
  logic [DW-1:0]   qd_next;
  logic [DW-1:0]   abs_in;

  assign abs_in  = dividend_i[DW-1] ? DW'(-dividend_i) : DW'(dividend_i);
  assign trial   = {rem_q, qd_q[DW-1]};
  assign ge      = trial >= (RW+1)'(DIVISOR);
  assign qd_next = {qd_q[DW-2:0], ge};

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      qd_q   <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      neg_q  <= 1'b0;
      done_o <= 1'b0;
      quot_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        mag_q <= abs_in;
        qd_q  <= abs_in;
        rem_q <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
        neg_q <= dividend_i[DW-1];
      end else if (run_q) begin
        rem_q <= ge ? RW'(trial - (RW+1)'(DIVISOR)) : RW'(trial);
        qd_q  <= qd_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNTW'(DW-1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
          quot_o <= neg_q ? -$signed(qd_next) : $signed(qd_next);
        end
      end
    end
  end

  assert_quotient_exact_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (32'(qd_q) * DIVISOR + 32'(rem_q) == 32'(mag_q)) && (32'(rem_q) < DIVISOR));
endmodule

// File: rtl/srm_synapse_array.sv
module srm_synapse_array
  import srm_pkg::*;
#(
  parameter int NV         = 9,
  parameter int NH         = 5,
  parameter int CW         = 8,
  parameter int WW         = 12,
  parameter int INIT_BITS  = 3,
  parameter int NORM_SHIFT = 1,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int NSYN  = NV * NH,
  localparam int IDXW  = $clog2(NSYN),
  localparam int DEPTH = 1 << IDXW,
  localparam int VW    = $clog2(NV),
  localparam int HW    = $clog2(NH),
  localparam int SUMW  = CW + 1 + $clog2(NSYN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_i,
  output logic            busy_o,
  input  logic            upd_valid_i,
  output logic            upd_ready_o,
  input  logic [IDXW-1:0] upd_idx_i,
  input  logic            upd_pos_i,
  input  logic            rd_req_i,
  input  logic [VW-1:0]   rd_vis_i,
  input  logic [HW-1:0]   rd_hid_i,
  output logic            rd_valid_o,
  output logic [WW-1:0]   rd_weight_o
);
  srm_state_e              state_q;
  logic                    busy_q;
  logic [IDXW-1:0]         cnt_q;
  logic [LFSR_W-1:0]       lfsr_q;
  logic signed [SUMW-1:0]  sum_q;
  logic signed [SUMW-1:0]  mean_q;
  logic                    start_q;
  logic                    div_done;
  logic signed [SUMW-1:0]  div_quot;

  // initial cell values from two shift-register steps per synapse
  logic [LFSR_W-1:0]       l1, l2;
  logic [CW-1:0]           init_pos, init_neg;
  logic signed [SUMW-1:0]  fill_diff;
  logic                    fill_we;

  assign l1        = lfsr_step(lfsr_q);
  assign l2        = lfsr_step(l1);
  assign init_pos  = CW'(l1[INIT_BITS-1:0]);
  assign init_neg  = CW'(l2[INIT_BITS-1:0]);
  assign fill_diff = $signed(SUMW'(init_pos)) - $signed(SUMW'(init_neg));
  assign fill_we   = (state_q == ST_FILL);

  // update path
  logic upd_hit;
  assign upd_ready_o = ~busy_q;
  assign busy_o      = busy_q;
  assign upd_hit     = upd_valid_i & ~busy_q & ({1'b0, upd_idx_i} < (IDXW+1)'(NSYN));

  // read path
  logic [IDXW-1:0] rd_idx;
  logic [CW-1:0]   pos_rd, neg_rd;
  assign rd_idx = IDXW'(rd_vis_i) * IDXW'(NH) + IDXW'(rd_hid_i);

  srm_cell_bank #(.CW(CW), .DEPTH(DEPTH)) u_pos_bank (
    .clk(clk), .rst(rst),
    .init_we(fill_we), .init_addr(cnt_q), .init_val(init_pos),
    .inc_en(upd_hit & upd_pos_i), .inc_addr(upd_idx_i),
    .rd_addr(rd_idx), .rd_val(pos_rd)
  );

  srm_cell_bank #(.CW(CW), .DEPTH(DEPTH)) u_neg_bank (
    .clk(clk), .rst(rst),
    .init_we(fill_we), .init_addr(cnt_q), .init_val(init_neg),
    .inc_en(upd_hit & ~upd_pos_i), .inc_addr(upd_idx_i),
    .rd_addr(rd_idx), .rd_val(neg_rd)
  );

  srm_mean_div #(.DW(SUMW), .DIVISOR(NSYN)) u_mean_div (
    .clk(clk), .rst(rst),
    .start_i(start_q), .dividend_i(sum_q),
    .done_o(div_done), .quot_o(div_quot)
  );

  // initialisation sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      lfsr_q  <= SEED;
      sum_q   <= '0;
      mean_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (init_i) begin
          state_q <= ST_FILL;
          busy_q  <= 1'b1;
          cnt_q   <= '0;
          lfsr_q  <= SEED;
          sum_q   <= '0;
        end
        ST_FILL: begin
          lfsr_q <= l2;
          sum_q  <= sum_q + fill_diff;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == IDXW'(NSYN - 1)) begin
            state_q <= ST_DIV;
            start_q <= 1'b1;
          end
        end
        ST_DIV: if (div_done) begin
          mean_q  <= div_quot;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // registered normalised read
  logic signed [SUMW-1:0] rd_diff, centered;
  assign rd_diff  = $signed(SUMW'(pos_rd)) - $signed(SUMW'(neg_rd));
  assign centered = rd_diff - mean_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o  <= 1'b0;
      rd_weight_o <= '0;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) rd_weight_o <= WW'(centered >>> NORM_SHIFT);
    end
  end

  assert_busy_needs_init_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(init_i));

  assert_mean_held_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !init_i) |=> $stable(mean_q));

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req_i |=> rd_valid_o);

  assert_fill_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    fill_we |-> ({1'b0, cnt_q} < (IDXW+1)'(NSYN)));
endmodule

// File: tb/srm_synapse_array_bench.sv
module srm_synapse_array_bench;
  localparam int NV = 9, NH = 5, NSYN = 45, SH = 1, IB = 3;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 0, rst = 1;
  logic init_i = 0, upd_valid_i = 0, upd_pos_i = 0, rd_req_i = 0;
  logic [5:0] upd_idx_i = 0;
  logic [3:0] rd_vis_i = 0;
  logic [2:0] rd_hid_i = 0;
  logic busy_o, upd_ready_o, rd_valid_o;
  logic [11:0] rd_weight_o;

  always #5 clk = ~clk;

  srm_synapse_array #(.NORM_SHIFT(SH), .SEED(SEED)) u_srm_synapse_array (
    .clk(clk), .rst(rst), .init_i(init_i), .busy_o(busy_o),
    .upd_valid_i(upd_valid_i), .upd_ready_o(upd_ready_o),
    .upd_idx_i(upd_idx_i), .upd_pos_i(upd_pos_i),
    .rd_req_i(rd_req_i), .rd_vis_i(rd_vis_i), .rd_hid_i(rd_hid_i),
    .rd_valid_o(rd_valid_o), .rd_weight_o(rd_weight_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int pos_m [NSYN];
  int neg_m [NSYN];
  int mean_m;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // model of initialisation (R3, R4)
  task automatic model_init();
    logic [15:0] s = SEED;
    int sum = 0;
    for (int i = 0; i < NSYN; i++) begin
      s = step(s); pos_m[i] = int'(s[IB-1:0]);
      s = step(s); neg_m[i] = int'(s[IB-1:0]);
      sum += pos_m[i] - neg_m[i];
    end
    mean_m = sum / NSYN;
  endtask

  task automatic run_init(input string req);
    int t = 0;
    @(negedge clk); init_i = 1;
    @(negedge clk); init_i = 0;
    check(busy_o == 1, "R2 busy after init", busy_o, 1);
    check(upd_ready_o == 0, "R2 ready low while busy", upd_ready_o, 0);
    @(negedge clk); init_i = 1;   // ignored while busy
    @(negedge clk); init_i = 0;
    while (busy_o && t < 1000) begin @(negedge clk); t++; end
    check(busy_o == 0, {req, " busy released"}, busy_o, 0);
    model_init();
  endtask

  task automatic upd(input int idx, input bit p);
    @(negedge clk);
    upd_valid_i = 1; upd_idx_i = 6'(idx); upd_pos_i = p;
    if (!upd_ready_o) check(0, "R6 ready for update", upd_ready_o, 1);
    if (idx < NSYN) begin
      if (p) pos_m[idx] = (pos_m[idx] < 255) ? pos_m[idx] + 1 : 255;
      else   neg_m[idx] = (neg_m[idx] < 255) ? neg_m[idx] + 1 : 255;
    end
  endtask

  task automatic upd_end();
    @(negedge clk); upd_valid_i = 0;
  endtask

  task automatic read_all(input string req);
    for (int v = 0; v < NV; v++)
      for (int h = 0; h < NH; h++) begin
        int s = v * NH + h;
        int exp = (pos_m[s] - neg_m[s] - mean_m) >>> SH;
        int act;
        @(negedge clk); rd_req_i = 1; rd_vis_i = 4'(v); rd_hid_i = 3'(h);
        @(negedge clk); rd_req_i = 0;
        act = int'($signed(rd_weight_o));
        check(rd_valid_o == 1 && act == exp, req, act, exp);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy_o == 0, "R1 busy after reset", busy_o, 0);
    check(upd_ready_o == 1, "R1 ready after reset", upd_ready_o, 1);
    check(rd_valid_o == 0, "R1 rd_valid after reset", rd_valid_o, 0);

    run_init("R2");
    read_all("R3 R4 R5 initial weight");

    // three epochs, one step per synapse, back to back
    for (int e = 0; e < 3; e++) begin
      for (int s = 0; s < NSYN; s++) upd(s, ((s * 7 + e * 3) % 5) < 2);
      upd_end();
      read_all("R6 R9 epoch weight");
    end

    // out-of-range indices change nothing
    for (int s = NSYN; s < 64; s++) begin upd(s, 1); upd(s, 0); end
    upd_end();
    read_all("R8 out-of-range ignored");

    // saturation of both cells of synapse 10
    for (int n = 0; n < 260; n++) upd(10, 1);
    upd_end();
    read_all("R7 positive cell saturates");
    for (int n = 0; n < 300; n++) upd(10, 0);
    upd_end();
    read_all("R7 negative cell saturates");

    run_init("R10");
    read_all("R10 R4 reinit weight");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule